// File: doc/BRIEF.md
# Monochrome Framebuffer Scanout with Shadowed CPU Writes

This block generates a raster video signal from a bit-per-pixel framebuffer held in its own video RAM. A horizontal and a vertical counter run freely on the pixel clock. They index two small timing tables that yield the sync pulses and the visible-area flags, and they also form the read address into the video RAM. Every sixteen pixel clocks a byte is fetched and loaded into a shift register, which sends the byte out most significant bit first. Each bit is held for two clocks and each framebuffer row is shown on two consecutive lines, so a 640x480 raster shows a 320x240 image.

The CPU sees a 32 KiB address window whose reads are served elsewhere (by system ROM) and whose writes land here. An accepted write is parked in a one-entry buffer and copied into the video RAM on the first clock that is not a fetch slot. The RAM therefore needs only one port, the CPU never waits, and the scanout never loses a fetch. A write that arrives while the buffer is still occupied is discarded and reported. The CPU never reads the video RAM back.

Top module: `vga_shadow_fb`

## Requirements
- R1: The horizontal position counts 0 to H_TOTAL-1 and wraps. The line counter advances on each wrap and itself wraps after V_TOTAL-1. Both are 0 in reset.
- R2: hsync_n is low exactly for horizontal positions in [H_SYNC_BEG, H_SYNC_END). All outputs lag the counter position by two clocks.
- R3: vsync_n is low exactly for lines in [V_SYNC_BEG, V_SYNC_END).
- R4: pixel is 0 whenever the position is outside the visible area (h >= H_VIS or line >= V_VIS).
- R5: Inside the visible area, pixel equals bit 7-((h mod 16)/2) of framebuffer byte (line/2)*(H_VIS/16) + h/16. Bit 7 is the leftmost pixel of a byte.
- R6: A CPU write to an address in [WIN_BASE, WIN_BASE+WIN_BYTES) stores its data at byte offset (address-WIN_BASE). An offset at or beyond the framebuffer size is accepted but changes no byte.
- R7: A CPU write outside the window is ignored. wr_busy stays low and no framebuffer byte changes.
- R8: wr_busy is high on the clock after an accepted write. It is low again two clocks later, because the commit is deferred by at most one clock. A commit never takes place on a fetch slot.
- R9: A write accepted while wr_busy is high is dropped. wr_drop pulses high for one clock on the following cycle, and the buffered write is kept.
- R10: During reset and on the first clock after it: hsync_n=1, vsync_n=1, pixel=0, wr_busy=0, wr_drop=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe, one clock per write |
| cpu_addr | input | CPU_AW | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| wr_busy | output | 1 | Write buffer holds an uncommitted write |
| wr_drop | output | 1 | One-clock pulse: a write was discarded |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pixel | output | 1 | Serial pixel data |

## Verification
The bench builds the block with a reduced raster: 64 clocks per line with 32 visible and sync at 40 to 47, and 20 lines per frame with 12 visible and sync on lines 14 and 15. The framebuffer then shrinks to 12 bytes and a whole frame lasts 1280 clocks. With these values many complete frames fit in the run, so frame wrap, vertical sync and the masking of every invisible region are all observed. Random writes then land on and next to fetch slots, and offsets just past the 12-byte store are exercised directly.

// File: rtl/vga_fb_pkg.sv
package vga_fb_pkg;
  localparam int BYTE_W     = 8;
  localparam int PIX_REP    = 2;
  localparam int FETCH_CLKS = BYTE_W * PIX_REP;
  localparam int FETCH_LG   = $clog2(FETCH_CLKS);

  typedef struct packed {
    logic vis;
    logic sync;
  } tim_t;
endpackage

// File: rtl/vga_scan_counter.sv
module vga_scan_counter #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hc,
  output logic [VW-1:0] vc
);
  localparam logic [HW-1:0] HLAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] VLAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= '0;
    end else if (hc == HLAST) begin
      hc <= '0;
      vc <= (vc == VLAST) ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  a_r1_h_in_range: assert property (@(posedge clk) disable iff (rst) hc <= HLAST);
  a_r1_v_in_range: assert property (@(posedge clk) disable iff (rst) vc <= VLAST);
  a_r1_h_wrap:     assert property (@(posedge clk) disable iff (rst) hc == HLAST |=> hc == '0);
  a_r1_v_hold:     assert property (@(posedge clk) disable iff (rst) hc != HLAST |=> $stable(vc));
endmodule

// File: rtl/vga_sync_rom.sv
module vga_sync_rom import vga_fb_pkg::*; #(
  parameter int TOTAL    = 800,
  parameter int VIS      = 640,
  parameter int SYNC_BEG = 656,
  parameter int SYNC_END = 752,
  localparam int AW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] idx,
  output tim_t          ent_q
);
  tim_t tab [TOTAL];

  for (genvar i = 0; i < TOTAL; i++) begin : g_tab
    assign tab[i] = {1'(i < VIS), 1'(i >= SYNC_BEG && i < SYNC_END)};
  end

  always_ff @(posedge clk) begin
    if (rst) ent_q <= '0;
    else     ent_q <= tab[idx];
  end

  a_r2_sync_blank: assert property (@(posedge clk) disable iff (rst) ent_q.sync |-> !ent_q.vis);
endmodule

// File: rtl/vga_wr_buffer.sv
module vga_wr_buffer import vga_fb_pkg::*; #(
  parameter int CPU_AW    = 16,
  parameter int WIN_BASE  = 32'h8000,
  parameter int WIN_BYTES = 32768,
  parameter int FB_BYTES  = 9600,
  parameter int VA        = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic              slot_taken,
  output logic              wr_en,
  output logic [VA-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              busy,
  output logic              drop
);
  localparam logic [CPU_AW:0] WIN_LO = (CPU_AW+1)'(WIN_BASE);
  localparam logic [CPU_AW:0] WIN_HI = (CPU_AW+1)'(WIN_BASE + WIN_BYTES);
  localparam logic [CPU_AW:0] FB_LIM = (CPU_AW+1)'(FB_BYTES);

  logic [CPU_AW:0] a_ext, off;
  logic            in_win, in_rng, acc;
  logic            valid, b_ok;

  always_comb begin
    a_ext  = {1'b0, cpu_addr};
    in_win = (a_ext >= WIN_LO) && (a_ext < WIN_HI);
    off    = a_ext - WIN_LO;
    in_rng = off < FB_LIM;
    acc    = cpu_we && in_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      b_ok    <= 1'b0;
      drop    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      drop <= 1'b0;
      if (valid && !slot_taken) valid <= 1'b0;
      if (acc) begin
        if (valid) begin
          drop <= 1'b1;
        end else begin
          valid   <= 1'b1;
          b_ok    <= in_rng;
          wr_addr <= off[VA-1:0];
          wr_data <= cpu_wdata;
        end
      end
    end
  end

  assign wr_en = valid && !slot_taken && b_ok;
  assign busy  = valid;

  a_r8_busy_short: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |=> !busy);
  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    drop |-> $past(busy));
  a_r7_outside_no_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_we && !in_win) |=> !busy);
endmodule

// File: rtl/vga_vram.sv
module vga_vram #(
  parameter int DEPTH = 9600,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/vga_shadow_fb.sv
module vga_shadow_fb import vga_fb_pkg::*; #(
  parameter int H_TOTAL    = 800,
  parameter int H_VIS      = 640,
  parameter int H_SYNC_BEG = 656,
  parameter int H_SYNC_END = 752,
  parameter int V_TOTAL    = 525,
  parameter int V_VIS      = 480,
  parameter int V_SYNC_BEG = 490,
  parameter int V_SYNC_END = 492,
  parameter int CPU_AW     = 16,
  parameter int WIN_BASE   = 32'h8000,
  parameter int WIN_BYTES  = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic              wr_busy,
  output logic              wr_drop,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              pixel
);
  localparam int HW       = $clog2(H_TOTAL);
  localparam int VW       = $clog2(V_TOTAL);
  localparam int BPL      = H_VIS / FETCH_CLKS;
  localparam int FB_BYTES = BPL * (V_VIS / PIX_REP);
  localparam int VA       = $clog2(FB_BYTES);
  localparam logic [HW-1:0] H_VIS_C = HW'(H_VIS);
  localparam logic [VW-1:0] V_VIS_C = VW'(V_VIS);

  logic [HW-1:0]     hc;
  logic [VW-1:0]     vc;
  tim_t              h_ent, v_ent;
  logic              fetch, fetch_d1, odd_d1;
  logic [VA-1:0]     scan_addr, wr_addr, ram_addr;
  logic [BYTE_W-1:0] wr_data, ram_rdata, shreg;
  logic              ram_we, cur_bit;

  vga_scan_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
    .clk(clk), .rst(rst), .hc(hc), .vc(vc)
  );

  vga_sync_rom #(.TOTAL(H_TOTAL), .VIS(H_VIS), .SYNC_BEG(H_SYNC_BEG), .SYNC_END(H_SYNC_END)) u_hrom (
    .clk(clk), .rst(rst), .idx(hc), .ent_q(h_ent)
  );

  vga_sync_rom #(.TOTAL(V_TOTAL), .VIS(V_VIS), .SYNC_BEG(V_SYNC_BEG), .SYNC_END(V_SYNC_END)) u_vrom (
    .clk(clk), .rst(rst), .idx(vc), .ent_q(v_ent)
  );

  always_comb begin
    fetch     = (hc < H_VIS_C) && (vc < V_VIS_C) && (hc[FETCH_LG-1:0] == '0);
    scan_addr = VA'((int'(vc) / PIX_REP) * BPL + int'(hc) / FETCH_CLKS);
    ram_addr  = fetch ? scan_addr : wr_addr;
  end

  vga_wr_buffer #(
    .CPU_AW(CPU_AW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
    .FB_BYTES(FB_BYTES), .VA(VA)
  ) u_wbuf (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .slot_taken(fetch), .wr_en(ram_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(wr_busy), .drop(wr_drop)
  );

  vga_vram #(.DEPTH(FB_BYTES), .DW(BYTE_W)) u_vram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(wr_data), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_d1 <= 1'b0;
      odd_d1   <= 1'b0;
    end else begin
      fetch_d1 <= fetch;
      odd_d1   <= hc[0];
    end
  end

  assign cur_bit = fetch_d1 ? ram_rdata[BYTE_W-1] : shreg[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst)           shreg <= '0;
    else if (fetch_d1) shreg <= ram_rdata;
    else if (odd_d1)   shreg <= {shreg[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      pixel   <= 1'b0;
    end else begin
      hsync_n <= !h_ent.sync;
      vsync_n <= !v_ent.sync;
      pixel   <= h_ent.vis && v_ent.vis && cur_bit;
    end
  end

  a_r5_no_commit_on_fetch: assert property (@(posedge clk) disable iff (rst) fetch |-> !ram_we);
  a_r4_dark_in_hsync: assert property (@(posedge clk) disable iff (rst) !hsync_n |-> !pixel);
  a_r4_dark_in_vsync: assert property (@(posedge clk) disable iff (rst) !vsync_n |-> !pixel);
endmodule

// File: tb/sim_vga_shadow_fb.sv
module sim_vga_shadow_fb;
  localparam int HT = 64, HV = 32, HS0 = 40, HS1 = 48;
  localparam int VT = 20, VV = 12, VS0 = 14, VS1 = 16;
  localparam int BPL = HV / 16;
  localparam int FB = BPL * (VV / 2);
  localparam int FRAME = HT * VT;
  localparam int WB = 32'h8000;

  logic clk = 1'b0;
  logic rst, cpu_we, wr_busy, wr_drop, hsync_n, vsync_n, pixel;
  logic [15:0] cpu_addr;
  logic [7:0] cpu_wdata;

  always #4 clk = ~clk;

  vga_shadow_fb #(
    .H_TOTAL(HT), .H_VIS(HV), .H_SYNC_BEG(HS0), .H_SYNC_END(HS1),
    .V_TOTAL(VT), .V_VIS(VV), .V_SYNC_BEG(VS0), .V_SYNC_END(VS1),
    .CPU_AW(16), .WIN_BASE(WB), .WIN_BYTES(32768)
  ) u0 (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .wr_busy(wr_busy), .wr_drop(wr_drop), .hsync_n(hsync_n), .vsync_n(vsync_n), .pixel(pixel)
  );

  int n_chk = 0, n_bad = 0;
  int ecnt = 0;
  int last_wr = 0;
  bit filled = 1'b0;
  bit done = 1'b0;
  logic [7:0] model [FB];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d)", tag, act, exp, ecnt - 2);
    end
  endtask

  function automatic logic exp_hs(input int p);
    int h = p % HT;
    return !(h >= HS0 && h < HS1);
  endfunction

  function automatic logic exp_vs(input int p);
    int v = (p / HT) % VT;
    return !(v >= VS0 && v < VS1);
  endfunction

  function automatic bit is_vis(input int p);
    return ((p % HT) < HV) && (((p / HT) % VT) < VV);
  endfunction

  function automatic logic exp_pix(input int p);
    int h = p % HT;
    int v = (p / HT) % VT;
    logic [7:0] b;
    if (!is_vis(p)) return 1'b0;
    b = model[(v / 2) * BPL + h / 16];
    return b[7 - ((h % 16) / 2)];
  endfunction

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  always @(negedge clk) begin
    int p;
    if (!rst && ecnt >= 2 && !done) begin
      p = ecnt - 2;
      check(hsync_n === exp_hs(p), "R2 hsync", int'(hsync_n), int'(exp_hs(p)));
      check(vsync_n === exp_vs(p), "R1/R3 vsync", int'(vsync_n), int'(exp_vs(p)));
      if (filled && (ecnt - last_wr) > FRAME + 8) begin
        if (is_vis(p)) check(pixel === exp_pix(p), "R5 pixel data", int'(pixel), int'(exp_pix(p)));
        else           check(pixel === 1'b0, "R4 blanking", int'(pixel), 0);
      end
    end
  end

  task automatic wr_win(input int off, input logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = 16'(WB + off); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    check(wr_busy === 1'b1, "R8 busy after accept", int'(wr_busy), 1);
    if (off < FB) begin
      model[off] = d;
      last_wr = ecnt;
    end
    repeat (2) @(negedge clk);
    check(wr_busy === 1'b0, "R8 commit done", int'(wr_busy), 0);
  endtask

  task automatic wr_out(input logic [15:0] a, input logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    check(wr_busy === 1'b0, "R7 outside window no busy", int'(wr_busy), 0);
    @(negedge clk);
  endtask

  task automatic wr_pair(input int o1, input logic [7:0] d1, input int o2, input logic [7:0] d2);
    cpu_we = 1'b1; cpu_addr = 16'(WB + o1); cpu_wdata = d1;
    @(negedge clk);
    check(wr_busy === 1'b1, "R8 busy on first", int'(wr_busy), 1);
    check(wr_drop === 1'b0, "R9 no drop on first", int'(wr_drop), 0);
    cpu_addr = 16'(WB + o2); cpu_wdata = d2;
    @(negedge clk);
    cpu_we = 1'b0;
    check(wr_drop === 1'b1, "R9 drop pulse", int'(wr_drop), 1);
    if (o1 < FB) begin
      model[o1] = d1;
      last_wr = ecnt;
    end
    @(negedge clk);
    check(wr_drop === 1'b0, "R9 drop one cycle", int'(wr_drop), 0);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ecnt, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < FB; i++) model[i] = 8'h00;
    rst = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    check(hsync_n === 1'b1, "R10 reset hsync", int'(hsync_n), 1);
    check(vsync_n === 1'b1, "R10 reset vsync", int'(vsync_n), 1);
    check(pixel === 1'b0, "R10 reset pixel", int'(pixel), 0);
    check(wr_busy === 1'b0, "R10 reset busy", int'(wr_busy), 0);
    check(wr_drop === 1'b0, "R10 reset drop", int'(wr_drop), 0);
    rst = 1'b0;
    @(negedge clk);
    check(hsync_n === 1'b1 && vsync_n === 1'b1 && pixel === 1'b0, "R10 first clock",
          int'({hsync_n, vsync_n, pixel}), 6);

    // R6: fill the whole framebuffer with a varied pattern
    for (int i = 0; i < FB; i++) wr_win(i, 8'((i * 37 + 5) ^ 8'hA5));
    filled = 1'b1;
    repeat (2 * FRAME + 20) @(negedge clk);

    // R7: addresses just below the window and low memory
    wr_out(16'h7FFF, 8'hFF);
    wr_out(16'h0003, 8'hFF);
    wr_out(16'h0000, 8'h00);
    // R6: offsets past the framebuffer are accepted but change nothing
    wr_win(FB + 3, 8'h5A);
    wr_win(FB, 8'h3C);
    wr_win(32767, 8'hC3);
    repeat (FRAME + 20) @(negedge clk);

    // R9: back-to-back, second dropped
    wr_pair(1, 8'h11, 2, 8'h22);
    wr_pair(FB - 1, 8'hF0, 0, 8'h0F);
    repeat (2 * FRAME + 20) @(negedge clk);

    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 40; k++) begin
        int off = int'($urandom % (FB + 4));
        logic [7:0] d = 8'($urandom);
        if (($urandom % 6) == 0) wr_pair(off, d, int'($urandom % FB), 8'($urandom));
        else                     wr_win(off, d);
        repeat ($urandom % 5) @(negedge clk);
      end
      repeat (2 * FRAME + 20) @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule